// File: doc/BRIEF.md
# SPI NOR Flash Command Engine

This block is the command layer of a serial NOR flash target. It sits behind a link that has already turned the serial wire into whole bytes. Each transfer strobe delivers one received byte. The engine answers with one response byte, which appears on its output right after that strobe's clock edge. A chip-select level frames each command. When the select is released, the engine drops whatever command it was in the middle of.

Inside the engine is a small byte array that stands for the flash contents. The engine decodes opcodes and gathers address and parameter bytes. It streams data out of the array and programs data into it. It answers status, identity and configuration queries. Addresses may be 3 or 4 bytes long. In 3-byte mode a segment register supplies the upper address bits. Erase is not carried out here: a qualified erase command is passed to a separate erase sequencer as a one-cycle request together with the full byte address. A two-step software reset returns the volatile settings to their power-on values and leaves the array contents in place.

Top module: `flash_eng_top`

## Requirements
- R1: While cs_n is high the engine returns to idle on every clock. The first byte after re-selection is decoded as an opcode, even if a command was cut short.
- R2: Opcode 0x05 prepares one status byte, which is returned on the next transfer. The status byte is {6'b0, WEL, 1'b0}. Opcode 0x06 sets WEL and opcode 0x04 clears it. After the status byte the engine is idle again.
- R3: Opcode 0x9F returns the 24-bit device ID over the next three transfers, most significant byte first. When EXT_ID_EN is 1, the two bytes of EXT_ID follow, high byte first. The engine is then idle.
- R4: Address bytes arrive most significant first. By default 3 address bytes are collected. Opcode 0xB7 switches to 4-byte addresses and opcode 0xE9 switches back.
- R5: With 3-byte addresses, the value of segment register bits [1:0] times 0x1000000 is added to the address. Opcode 0xC8 reads the segment register. Opcode 0xC5 followed by one byte writes it, but only when WEL is set; otherwise that byte is consumed and the register is unchanged.
- R6: Opcode 0x03 followed by an address starts a streaming read. Each further transfer returns the array byte at the current address, then advances the address modulo MEM_BYTES, so the read wraps from the last byte to address 0.
- R7: Opcode 0x0B collects the address plus a number of dummy bytes equal to config bits [7:4], then streams like R6. Opcode 0x81 followed by one byte writes the config register (WEL required). Opcode 0x85 reads it. Its reset value is VCFG_RST (0x10, one dummy byte).
- R8: Opcode 0x02 followed by an address programs each further byte at an advancing address that wraps like R6. The stored value is old AND new, or simply the new byte when OVERWRITE is 1. If WEL was clear when the address completed, the data bytes are ignored.
- R9: WEL is cleared as soon as the address or parameter collection of a program, erase or register-write command completes.
- R10: Opcode 0xD8 followed by an address, with WEL set, raises erase_req for exactly one cycle, with the full address on erase_addr. Without WEL, no request is raised.
- R11: Opcode 0x99 resets the engine only if the opcode directly before it was 0x66. Any other opcode cancels a pending 0x66. The reset clears WEL, selects 3-byte addresses, clears the segment register and reloads VCFG_RST. Array contents are kept.
- R12: Hardware reset fills the array with 0xFF and sets tx_byte to 0x00. Opcodes not listed here are ignored and leave the engine idle. Every opcode, address, dummy and program transfer returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| cs_n | input | 1 | Active-low chip select level |
| xfer_vld | input | 1 | Strobe: one received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Response to the most recent accepted transfer |
| erase_req | output | 1 | One-cycle erase request to the erase sequencer |
| erase_addr | output | 32 | Full byte address of the erase request |

## Verification
Streaming reads are run from mid-array addresses and from the last byte, which separates correct wrap-around from an unbounded address. Programming is tried over erased bytes, over already-programmed bytes with WEL set and with WEL clear; this separates AND-merge, overwrite and a missing write-enable gate. Address assembly is observed through the erase request in 3-byte mode with a non-zero segment register and in 4-byte mode, and again after a software reset, which exposes any wrong byte count or wrong segment addition. Reset sequences with and without an intervening opcode separate a correct two-step arm from a one-step or sticky one.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_RESP    = 3'd2,
        ST_STREAM  = 3'd3,
        ST_PROG    = 3'd4
    } eng_state_e;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_IDENT  = 8'h9F;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_ERASE  = 8'hD8;
    localparam logic [7:0] OP_ADDR4  = 8'hB7;
    localparam logic [7:0] OP_ADDR3  = 8'hE9;
    localparam logic [7:0] OP_SEG_RD = 8'hC8;
    localparam logic [7:0] OP_SEG_WR = 8'hC5;
    localparam logic [7:0] OP_CFG_WR = 8'h81;
    localparam logic [7:0] OP_CFG_RD = 8'h85;
    localparam logic [7:0] OP_ARM    = 8'h66;
    localparam logic [7:0] OP_SWRST  = 8'h99;

endpackage

// File: rtl/flash_eng_addr.sv
module flash_eng_addr #(
    parameter int ADDR_W    = 32,
    parameter int SEG_SHIFT = 24
) (
    input  logic [ADDR_W-1:0] sh,
    input  logic              four_b,
    input  logic [1:0]        seg,
    output logic [ADDR_W-1:0] addr
);
    localparam int LOW_W = SEG_SHIFT;

    logic [ADDR_W-1:0] low_part;
    logic [ADDR_W-1:0] seg_part;

    always_comb begin
        low_part = {{(ADDR_W-LOW_W){1'b0}}, sh[LOW_W-1:0]};
        seg_part = {{(ADDR_W-2){1'b0}}, seg} << SEG_SHIFT;
        if (four_b) begin
            addr = sh;
        end else begin
            addr = low_part + seg_part;
        end
    end
endmodule

// File: rtl/flash_eng_mem.sv
module flash_eng_mem #(
    parameter int MEM_BYTES = 256,
    parameter bit OVERWRITE = 1'b0,
    localparam int IDX_W    = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data
);
    logic [7:0] mem_q [MEM_BYTES];
    logic [7:0] cell_d;

    assign rd_data = mem_q[rd_idx];

    generate
        if (OVERWRITE) begin : g_direct
            always_comb cell_d = wr_data;
        end else begin : g_clear_only
            always_comb cell_d = mem_q[wr_idx] & wr_data;

            // R8: an AND-merge write never raises a bit that was 0
            a_r8_bits_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> ((mem_q[$past(wr_idx)] & ~$past(mem_q[wr_idx])) == 8'h00));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= cell_d;
        end
    end
endmodule

// File: rtl/flash_eng_ctrl.sv
module flash_eng_ctrl
    import flash_eng_pkg::*;
#(
    parameter int          MEM_BYTES = 256,
    parameter logic [23:0] DEV_ID    = 24'h5A3C11,
    parameter logic [15:0] EXT_ID    = 16'h0042,
    parameter bit          EXT_ID_EN = 1'b1,
    parameter logic [7:0]  VCFG_RST  = 8'h10,
    localparam int IDX_W    = $clog2(MEM_BYTES),
    localparam int ADDR_W   = 32,
    localparam int MAX_NEED = 4 + 15,
    localparam int CNT_W    = $clog2(MAX_NEED + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              xfer_vld,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        tx_byte,
    output logic              erase_req,
    output logic [ADDR_W-1:0] erase_addr,
    output logic [IDX_W-1:0]  mem_rd_idx,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [IDX_W-1:0]  mem_wr_idx,
    output logic [7:0]        mem_wr_data,
    output logic [ADDR_W-1:0] asm_sh,
    output logic              asm_four,
    output logic [1:0]        asm_seg,
    input  logic [ADDR_W-1:0] full_addr
);
    typedef struct packed {
        eng_state_e        st;
        logic [7:0]        cmd;
        logic [CNT_W-1:0]  got;
        logic [CNT_W-1:0]  need;
        logic [ADDR_W-1:0] sh;
        logic [IDX_W-1:0]  cur;
        logic              wel;
        logic              arm;
        logic              four_b;
        logic [7:0]        seg;
        logic [7:0]        vcfg;
        logic [39:0]       rsp;
        logic [2:0]        left;
        logic              pgm_ok;
        logic [7:0]        tx;
        logic              erase_req;
        logic [ADDR_W-1:0] erase_addr;
    } eng_regs_t;

    eng_regs_t r_q, r_d;

    logic [CNT_W-1:0]  alen;
    logic [ADDR_W-1:0] sh_next;
    logic              addr_byte;
    logic              last_byte;

    always_comb begin
        alen      = r_q.four_b ? CNT_W'(4) : CNT_W'(3);
        sh_next   = {r_q.sh[ADDR_W-9:0], rx_byte};
        addr_byte = (r_q.got < alen);
        last_byte = ((r_q.got + 1'b1) == r_q.need);
        asm_sh    = addr_byte ? sh_next : r_q.sh;
        asm_four  = r_q.four_b;
        asm_seg   = r_q.seg[1:0];
    end

    always_comb begin
        r_d           = r_q;
        r_d.erase_req = 1'b0;
        mem_rd_idx    = r_q.cur;
        mem_wr_idx    = r_q.cur;
        mem_wr_data   = rx_byte;
        mem_wr_en     = 1'b0;

        if (cs_n) begin
            r_d.st = ST_IDLE;
        end else if (xfer_vld) begin
            r_d.tx = 8'h00;
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.cmd = rx_byte;
                    r_d.got = '0;
                    if (rx_byte != OP_SWRST) begin
                        r_d.arm = 1'b0;
                    end
                    case (rx_byte)
                        OP_WREN: r_d.wel = 1'b1;
                        OP_WRDI: r_d.wel = 1'b0;
                        OP_STATUS: begin
                            r_d.rsp  = {6'b0, r_q.wel, 1'b0, 32'h0};
                            r_d.left = 3'd1;
                            r_d.st   = ST_RESP;
                        end
                        OP_IDENT: begin
                            r_d.rsp  = {DEV_ID, EXT_ID};
                            r_d.left = EXT_ID_EN ? 3'd5 : 3'd3;
                            r_d.st   = ST_RESP;
                        end
                        OP_SEG_RD: begin
                            r_d.rsp  = {r_q.seg, 32'h0};
                            r_d.left = 3'd1;
                            r_d.st   = ST_RESP;
                        end
                        OP_CFG_RD: begin
                            r_d.rsp  = {r_q.vcfg, 32'h0};
                            r_d.left = 3'd1;
                            r_d.st   = ST_RESP;
                        end
                        OP_READ, OP_PROG, OP_ERASE: begin
                            r_d.need = alen;
                            r_d.st   = ST_COLLECT;
                        end
                        OP_FREAD: begin
                            r_d.need = alen + CNT_W'(r_q.vcfg[7:4]);
                            r_d.st   = ST_COLLECT;
                        end
                        OP_SEG_WR, OP_CFG_WR: begin
                            r_d.need = CNT_W'(1);
                            r_d.st   = ST_COLLECT;
                        end
                        OP_ADDR4: r_d.four_b = 1'b1;
                        OP_ADDR3: r_d.four_b = 1'b0;
                        OP_ARM:   r_d.arm    = 1'b1;
                        OP_SWRST: begin
                            if (r_q.arm) begin
                                r_d.wel    = 1'b0;
                                r_d.four_b = 1'b0;
                                r_d.seg    = 8'h00;
                                r_d.vcfg   = VCFG_RST;
                            end
                            r_d.arm = 1'b0;
                        end
                        default: ;
                    endcase
                end

                ST_COLLECT: begin
                    r_d.got = r_q.got + 1'b1;
                    if (addr_byte) begin
                        r_d.sh = sh_next;
                    end
                    if (last_byte) begin
                        r_d.st = ST_IDLE;
                        case (r_q.cmd)
                            OP_READ, OP_FREAD: begin
                                r_d.cur = full_addr[IDX_W-1:0];
                                r_d.st  = ST_STREAM;
                            end
                            OP_PROG: begin
                                r_d.cur    = full_addr[IDX_W-1:0];
                                r_d.pgm_ok = r_q.wel;
                                r_d.wel    = 1'b0;
                                r_d.st     = ST_PROG;
                            end
                            OP_ERASE: begin
                                if (r_q.wel) begin
                                    r_d.erase_req  = 1'b1;
                                    r_d.erase_addr = full_addr;
                                end
                                r_d.wel = 1'b0;
                            end
                            OP_SEG_WR: begin
                                if (r_q.wel) begin
                                    r_d.seg = rx_byte;
                                end
                                r_d.wel = 1'b0;
                            end
                            OP_CFG_WR: begin
                                if (r_q.wel) begin
                                    r_d.vcfg = rx_byte;
                                end
                                r_d.wel = 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end

                ST_RESP: begin
                    r_d.tx   = r_q.rsp[39:32];
                    r_d.rsp  = {r_q.rsp[31:0], 8'h00};
                    r_d.left = r_q.left - 3'd1;
                    if (r_q.left == 3'd1) begin
                        r_d.st = ST_IDLE;
                    end
                end

                ST_STREAM: begin
                    r_d.tx  = mem_rd_data;
                    r_d.cur = r_q.cur + 1'b1;
                end

                ST_PROG: begin
                    mem_wr_en = r_q.pgm_ok;
                    r_d.cur   = r_q.cur + 1'b1;
                end

                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.vcfg <= VCFG_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_byte    = r_q.tx;
    assign erase_req  = r_q.erase_req;
    assign erase_addr = r_q.erase_addr;

    // R1: a released select always lands the engine in idle
    a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (r_q.st == ST_IDLE));

    // R11: any opcode other than the arm opcode leaves the engine disarmed
    a_r11_arm_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && xfer_vld && r_q.st == ST_IDLE && rx_byte != OP_ARM) |=> !r_q.arm);

    // R9: an erase request is never seen while write enable is still set
    a_r9_erase_drops_wel: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.erase_req |-> !r_q.wel);

    // R10: the erase request is a single-cycle pulse
    a_r10_erase_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.erase_req |=> !r_q.erase_req);

    // R3: the response state always holds at least one pending byte
    a_r3_resp_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RESP) |-> (r_q.left != 3'd0));
endmodule

// File: rtl/flash_eng_top.sv
module flash_eng_top #(
    parameter int          MEM_BYTES = 256,
    parameter logic [23:0] DEV_ID    = 24'h5A3C11,
    parameter logic [15:0] EXT_ID    = 16'h0042,
    parameter bit          EXT_ID_EN = 1'b1,
    parameter logic [7:0]  VCFG_RST  = 8'h10,
    parameter bit          OVERWRITE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        xfer_vld,
    input  logic [7:0]  rx_byte,
    output logic [7:0]  tx_byte,
    output logic        erase_req,
    output logic [31:0] erase_addr
);
    localparam int IDX_W  = $clog2(MEM_BYTES);
    localparam int ADDR_W = 32;

    logic [IDX_W-1:0]  rd_idx;
    logic [7:0]        rd_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [7:0]        wr_data;
    logic [ADDR_W-1:0] asm_sh;
    logic              asm_four;
    logic [1:0]        asm_seg;
    logic [ADDR_W-1:0] full_addr;

    flash_eng_ctrl #(
        .MEM_BYTES (MEM_BYTES),
        .DEV_ID    (DEV_ID),
        .EXT_ID    (EXT_ID),
        .EXT_ID_EN (EXT_ID_EN),
        .VCFG_RST  (VCFG_RST)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .xfer_vld    (xfer_vld),
        .rx_byte     (rx_byte),
        .tx_byte     (tx_byte),
        .erase_req   (erase_req),
        .erase_addr  (erase_addr),
        .mem_rd_idx  (rd_idx),
        .mem_rd_data (rd_data),
        .mem_wr_en   (wr_en),
        .mem_wr_idx  (wr_idx),
        .mem_wr_data (wr_data),
        .asm_sh      (asm_sh),
        .asm_four    (asm_four),
        .asm_seg     (asm_seg),
        .full_addr   (full_addr)
    );

    flash_eng_addr #(
        .ADDR_W    (ADDR_W),
        .SEG_SHIFT (24)
    ) addr_i (
        .sh     (asm_sh),
        .four_b (asm_four),
        .seg    (asm_seg),
        .addr   (full_addr)
    );

    flash_eng_mem #(
        .MEM_BYTES (MEM_BYTES),
        .OVERWRITE (OVERWRITE)
    ) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );
endmodule

// File: tb/flash_eng_top_tb_top.sv
module flash_eng_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        xfer_vld = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [7:0]  tx_byte;
    logic        erase_req;
    logic [31:0] erase_addr;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [7:0] last_tx;

    always #2 clk = ~clk;

    flash_eng_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .xfer_vld   (xfer_vld),
        .rx_byte    (rx_byte),
        .tx_byte    (tx_byte),
        .erase_req  (erase_req),
        .erase_addr (erase_addr)
    );

    // vector: {new frame, byte sent, expected response, compare, requirement}
    function automatic logic [21:0] vec(input bit s, input logic [7:0] b,
                                        input logic [7:0] e, input bit c,
                                        input int unsigned q);
        return {s, b, e, c, q[3:0]};
    endfunction

    function automatic string req_tag(input logic [3:0] q);
        case (q)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd12:   return "R12";
            default: return "R?";
        endcase
    endfunction

    localparam int NV = 52;
    localparam logic [21:0] TBL [NV] = '{
        vec(1, 8'h05, 8'h00, 0, 0), vec(0, 8'h00, 8'h00, 1, 2),
        vec(1, 8'h06, 8'h00, 0, 0),
        vec(1, 8'h05, 8'h00, 0, 0), vec(0, 8'h00, 8'h02, 1, 2),
        vec(1, 8'h9F, 8'h00, 0, 0), vec(0, 8'h00, 8'h5A, 1, 3),
        vec(0, 8'h00, 8'h3C, 1, 3), vec(0, 8'h00, 8'h11, 1, 3),
        vec(0, 8'h00, 8'h00, 1, 3), vec(0, 8'h00, 8'h42, 1, 3),
        vec(1, 8'h02, 8'h00, 0, 0), vec(0, 8'h00, 8'h00, 0, 0),
        vec(0, 8'h00, 8'h00, 0, 0), vec(0, 8'h10, 8'h00, 1, 12),
        vec(0, 8'h3C, 8'h00, 0, 0), vec(0, 8'hF0, 8'h00, 0, 0),
        vec(1, 8'h05, 8'h00, 0, 0), vec(0, 8'h00, 8'h00, 1, 9),
        vec(1, 8'h03, 8'h00, 0, 0), vec(0, 8'h00, 8'h00, 0, 0),
        vec(0, 8'h00, 8'h00, 0, 0), vec(0, 8'h10, 8'h00, 0, 0),
        vec(0, 8'h00, 8'h3C, 1, 6), vec(0, 8'h00, 8'hF0, 1, 6),
        vec(0, 8'h00, 8'hFF, 1, 6),
        vec(1, 8'h06, 8'h00, 0, 0),
        vec(1, 8'h02, 8'h00, 0, 0), vec(0, 8'h00, 8'h00, 0, 0),
        vec(0, 8'h00, 8'h00, 0, 0), vec(0, 8'h10, 8'h00, 0, 0),
        vec(0, 8'h0F, 8'h00, 0, 0),
        vec(1, 8'h02, 8'h00, 0, 0), vec(0, 8'h00, 8'h00, 0, 0),
        vec(0, 8'h00, 8'h00, 0, 0), vec(0, 8'h11, 8'h00, 0, 0),
        vec(0, 8'h00, 8'h00, 0, 0),
        vec(1, 8'h03, 8'h00, 0, 0), vec(0, 8'h00, 8'h00, 0, 0),
        vec(0, 8'h00, 8'h00, 0, 0), vec(0, 8'h10, 8'h00, 0, 0),
        vec(0, 8'h00, 8'h0C, 1, 8), vec(0, 8'h00, 8'hF0, 1, 8),
        vec(1, 8'h0B, 8'h00, 0, 0), vec(0, 8'h00, 8'h00, 0, 0),
        vec(0, 8'h00, 8'h00, 0, 0), vec(0, 8'h10, 8'h00, 0, 0),
        vec(0, 8'h00, 8'h00, 1, 7), vec(0, 8'h00, 8'h0C, 1, 7),
        vec(1, 8'h42, 8'h00, 1, 12), vec(0, 8'h05, 8'h00, 1, 12),
        vec(0, 8'h00, 8'h00, 1, 2)
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic frame();
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) cs_n = 1'b0;
    endtask

    task automatic xb(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        xfer_vld = 1'b1;
        @(posedge clk);
        #1;
        xfer_vld = 1'b0;
        last_tx  = tx_byte;
    endtask

    task automatic cmd1(input logic [7:0] op);
        frame();
        xb(op);
    endtask

    task automatic read1(input logic [7:0] op, input string tag, input logic [7:0] exp);
        frame();
        xb(op);
        xb(8'h00);
        check(tag, {24'h0, last_tx}, {24'h0, exp});
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R12 reset tx", {24'h0, tx_byte}, 32'h0);
        check("R12 reset erase_req", {31'h0, erase_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i][21]) frame();
            xb(TBL[i][20:13]);
            if (TBL[i][4]) begin
                check(req_tag(TBL[i][3:0]), {24'h0, last_tx}, {24'h0, TBL[i][12:5]});
            end
        end

        // R6 / R8: program across the top of the array, then read across it
        cmd1(8'h06);
        frame(); xb(8'h02); xb(8'h00); xb(8'h00); xb(8'hFF); xb(8'hA5); xb(8'h5A);
        frame(); xb(8'h03); xb(8'h00); xb(8'h00); xb(8'hFF);
        xb(8'h00); check("R6 read at last byte", {24'h0, last_tx}, 32'hA5);
        xb(8'h00); check("R6 r8_ read wraps to 0", {24'h0, last_tx}, 32'h5A);

        // R5: segment register write, gated write, read back, use in address
        cmd1(8'h06);
        frame(); xb(8'hC5); xb(8'h02);
        read1(8'hC8, "R5 segment written", 8'h02);
        frame(); xb(8'hC5); xb(8'h03);
        read1(8'hC8, "R5 segment write without WEL", 8'h02);
        cmd1(8'h06);
        frame(); xb(8'hD8); xb(8'h00); xb(8'h12); xb(8'h34);
        check("R10 erase_req raised", {31'h0, erase_req}, 32'h1);
        check("R5 segment added", erase_addr, 32'h0200_1234);
        @(posedge clk); #1;
        check("R10 erase_req one cycle", {31'h0, erase_req}, 32'h0);
        read1(8'h05, "R9 WEL cleared by erase", 8'h00);

        // R4: 4-byte addresses ignore the segment register
        cmd1(8'hB7);
        cmd1(8'h06);
        frame(); xb(8'hD8); xb(8'h01); xb(8'h00); xb(8'h00); xb(8'h40);
        check("R4 four-byte erase addr", erase_addr, 32'h0100_0040);
        check("R4 four-byte erase req", {31'h0, erase_req}, 32'h1);
        frame(); xb(8'h03); xb(8'h00); xb(8'h00); xb(8'h00); xb(8'h10);
        xb(8'h00); check("R4 four-byte read", {24'h0, last_tx}, 32'h0C);
        cmd1(8'hE9);
        cmd1(8'h06);
        frame(); xb(8'hD8); xb(8'h00); xb(8'h00); xb(8'h40);
        check("R4 back to three bytes", erase_addr, 32'h0200_0040);

        // R10: erase without write enable
        frame(); xb(8'hD8); xb(8'h00); xb(8'h00); xb(8'h40);
        check("R10 no erase without WEL", {31'h0, erase_req}, 32'h0);

        // R7: three dummy bytes after a config write
        cmd1(8'h06);
        frame(); xb(8'hC1 - 8'h40); xb(8'h30);
        read1(8'h85, "R7 config written", 8'h30);
        frame(); xb(8'h0B); xb(8'h00); xb(8'h00); xb(8'h10);
        xb(8'h00); xb(8'h00); xb(8'h00);
        check("R7 last dummy returns zero", {24'h0, last_tx}, 32'h00);
        xb(8'h00); check("R7 data after three dummies", {24'h0, last_tx}, 32'h0C);

        // R1: a command cut short by deselect
        cmd1(8'h06);
        frame(); xb(8'h03); xb(8'h00);
        read1(8'h05, "R1 opcode after abort", 8'h02);

        // R11: reset needs the arm opcode directly before it
        cmd1(8'h66);
        read1(8'h85, "R11 config before reset", 8'h30);
        cmd1(8'h99);
        read1(8'h05, "R11 reset not armed", 8'h02);
        cmd1(8'hB7);
        cmd1(8'h66);
        cmd1(8'h99);
        read1(8'h05, "R11 WEL cleared", 8'h00);
        read1(8'h85, "R11 config reloaded", 8'h10);
        read1(8'hC8, "R11 segment cleared", 8'h00);
        cmd1(8'h06);
        frame(); xb(8'hD8); xb(8'h00); xb(8'h00); xb(8'h40);
        check("R11 three-byte mode restored", erase_addr, 32'h0000_0040);
        frame(); xb(8'h03); xb(8'h00); xb(8'h00); xb(8'h10);
        xb(8'h00); check("R11 array kept", {24'h0, last_tx}, 32'h0C);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule